// File: doc/BRIEF.md
# JTAG Configuration Readback Sequencer

This block acts as a JTAG host that reads back the configuration memory of one attached device. After a start request it drives TCK, TMS and TDI and samples TDO by itself. It first puts the device's TAP into its reset state. It then loads an instruction that opens configuration access and a second one that sets the frame address to its initial value. For every configuration frame it issues a read instruction and shifts the whole frame out through the data register. Finally it closes configuration access again.

While the frames stream in, a 16-bit checksum is accumulated over the read data. The checksum and the number of frames read stay on the outputs after the run. A host uses the block as follows. It picks a TCK half-period in system clock cycles that keeps TCK within the device's limit of 65 MHz. It then pulses start and waits for the done pulse.

Top module: `jrb_readback_seq`

## Requirements
- R1: After reset busy_o, done_o, tck_o and tdi_o are 0, tms_o is 1, and checksum_o and frames_o are 0.
- R2: While busy, every low phase and every high phase of tck_o lasts exactly half_per_i+1 clock cycles, with half_per_i taken at start. The first phase after start is low. tck_o is 0 whenever the block is idle.
- R3: tms_o and tdi_o change only in the clock cycle in which tck_o falls. tdo_i is sampled in the cycle in which tck_o rises.
- R4: Each run begins with RESET_TCKS (at least 5) rising TCK edges with TMS high. The next rising edge has TMS low, which moves the TAP from Test-Logic-Reset to Run-Test/Idle.
- R5: An instruction is loaded from Run-Test/Idle through Select-DR, Select-IR, Capture-IR and Shift-IR. It is shifted in as exactly 8 bits, least significant bit first, and TMS is high on the last bit. The scan returns through Update-IR to Run-Test/Idle.
- R6: The instructions loaded in one run are, in order: 0x15 (open configuration), 0x12 (initialise address), then 0x03 (read) once per frame for FRAME_COUNT frames, and last 0x3A (close configuration).
- R7: Each read instruction is followed by one data scan through Select-DR, Capture-DR and Shift-DR. The scan takes exactly FRAME_BITS bits with TDI held at 0 and leaves via Exit1-DR and Update-DR to Run-Test/Idle. The TAP ends the run in Run-Test/Idle.
- R8: checksum_o is the sum modulo 2^16 of the read data taken as consecutive 16-bit words in sampling order. The first sampled bit of each word is the word's bit 15.
- R9: frames_o counts completed frame scans and ends the run at FRAME_COUNT. Both results are cleared at start and hold their values while idle.
- R10: A start pulse while idle sets busy_o in the next cycle. done_o is high for one cycle, in the cycle in which busy_o falls. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a readback run when idle |
| half_per_i | input | DIV_W | TCK half-period minus one, in clock cycles |
| tdo_i | input | 1 | Serial data from the device |
| tck_o | output | 1 | Test clock to the device |
| tms_o | output | 1 | Test mode select to the device |
| tdi_o | output | 1 | Serial data to the device |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| checksum_o | output | CHK_W | Accumulated read-data checksum |
| frames_o | output | FCNT_W | Number of frames read back |

## Verification
The assertions take for granted three things about the device. It presents each TDO bit from a falling TCK edge until the next rising edge. half_per_i is stable for the duration of the start pulse. start_i is never asserted together with reset. The bench meets these with a behavioural TAP model. This model changes TDO only on falling TCK. It generates frame data from a seeded mixing function, so the checksum can be predicted. The bench drives half_per_i and start_i only at falling clock edges, with a random seed and half-period for each run. A start pulse in the middle of one run covers the busy case.

// File: rtl/jrb_pkg.sv
package jrb_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_RST,
      PH_RTI0,
      PH_IR_HEAD,
      PH_IR_SHIFT,
      PH_IR_TAIL,
      PH_DR_HEAD,
      PH_DR_SHIFT,
      PH_DR_TAIL,
      PH_FIN
   } phase_e;

   typedef enum logic [1:0] {
      CMD_OPEN,
      CMD_ADDR,
      CMD_READ,
      CMD_CLOSE
   } cmd_e;

   // TMS steps around a scan: RTI->SelDR->SelIR->CapIR->ShIR
   localparam int IR_HEAD_LEN = 4;
   // RTI->SelDR->CapDR->ShDR
   localparam int DR_HEAD_LEN = 3;
   // Exit1->Update->RTI
   localparam int TAIL_LEN    = 2;

endpackage

// File: rtl/jrb_tck_gen.sv
module jrb_tck_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             tck_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             tck_q;
   logic             term;

   assign term   = run_i && (cnt_q == half_i);
   assign rise_o = term && !tck_q;
   assign fall_o = term &&  tck_q;
   assign tck_o  = tck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tck_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         tck_q <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         tck_q <= ~tck_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> tck_o);

endmodule

// File: rtl/jrb_checksum.sv
module jrb_checksum #(
   parameter int CHK_W     = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             vld_i,
   input  logic             bit_i,
   output logic [CHK_W-1:0] sum_o
);

   localparam int POS_W = $clog2(CHK_W);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(CHK_W - 1);

   logic [CHK_W-2:0] sr_q;
   logic [POS_W-1:0] pos_q;
   logic [CHK_W-1:0] sum_q;
   logic [CHK_W-1:0] word;
   logic [CHK_W-2:0] sr_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign word    = {sr_q, bit_i};
         assign sr_next = {sr_q[CHK_W-3:0], bit_i};
      end else begin : g_lsb
         assign word    = {bit_i, sr_q};
         assign sr_next = {bit_i, sr_q[CHK_W-2:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         pos_q <= '0;
         sum_q <= '0;
      end else if (clr_i) begin
         sr_q  <= '0;
         pos_q <= '0;
         sum_q <= '0;
      end else if (vld_i) begin
         if (pos_q == LAST_POS) begin
            sum_q <= sum_q + word;
            pos_q <= '0;
            sr_q  <= '0;
         end else begin
            sr_q  <= sr_next;
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   assign sum_o = sum_q;

   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (sum_o == '0));

endmodule

// File: rtl/jrb_tap_walker.sv
module jrb_tap_walker
   import jrb_pkg::*;
#(
   parameter int              IR_LEN      = 8,
   parameter int              FRAME_BITS  = 3376,
   parameter int              FRAME_COUNT = 1342,
   parameter int              RESET_TCKS  = 5,
   parameter logic [IR_LEN-1:0] CODE_OPEN  = 8'h15,
   parameter logic [IR_LEN-1:0] CODE_ADDR  = 8'h12,
   parameter logic [IR_LEN-1:0] CODE_READ  = 8'h03,
   parameter logic [IR_LEN-1:0] CODE_CLOSE = 8'h3A,
   parameter int              FCNT_W      = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              tdo_i,
   output logic              tms_o,
   output logic              tdi_o,
   output logic              bit_vld_o,
   output logic              bit_o,
   output logic              finish_o,
   output logic [FCNT_W-1:0] frames_o
);

   localparam int CNT_W = $clog2(FRAME_BITS + RESET_TCKS + IR_LEN + 1);
   localparam int IRI_W = (IR_LEN > 1) ? $clog2(IR_LEN) : 1;
   localparam logic [CNT_W-1:0] L_RST  = CNT_W'(RESET_TCKS - 1);
   localparam logic [CNT_W-1:0] L_IRH  = CNT_W'(IR_HEAD_LEN - 1);
   localparam logic [CNT_W-1:0] L_IRS  = CNT_W'(IR_LEN - 1);
   localparam logic [CNT_W-1:0] L_DRH  = CNT_W'(DR_HEAD_LEN - 1);
   localparam logic [CNT_W-1:0] L_DRS  = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] L_TAIL = CNT_W'(TAIL_LEN - 1);
   localparam logic [FCNT_W-1:0] L_FRM = FCNT_W'(FRAME_COUNT - 1);

   phase_e            phase_q;
   cmd_e              cmd_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [FCNT_W-1:0] frames_q;
   logic              tms_q, tdi_q;

   logic [CNT_W-1:0]  seg_last;
   logic              tms_n, tdi_n;
   logic [IR_LEN-1:0] cur_code;

   always_comb begin
      case (cmd_q)
         CMD_OPEN: cur_code = CODE_OPEN;
         CMD_ADDR: cur_code = CODE_ADDR;
         CMD_READ: cur_code = CODE_READ;
         default:  cur_code = CODE_CLOSE;
      endcase
   end

   // last count value of each segment and the TMS/TDI for the next rise
   always_comb begin
      seg_last = '0;
      tms_n    = 1'b1;
      tdi_n    = 1'b0;
      case (phase_q)
         PH_RST:      begin seg_last = L_RST;  tms_n = 1'b1; end
         PH_RTI0:     begin seg_last = '0;     tms_n = 1'b0; end
         PH_IR_HEAD:  begin seg_last = L_IRH;  tms_n = (cnt_q < CNT_W'(2)); end
         PH_IR_SHIFT: begin
            seg_last = L_IRS;
            tms_n    = (cnt_q == L_IRS);
            tdi_n    = cur_code[cnt_q[IRI_W-1:0]];
         end
         PH_IR_TAIL:  begin seg_last = L_TAIL; tms_n = (cnt_q == '0); end
         PH_DR_HEAD:  begin seg_last = L_DRH;  tms_n = (cnt_q == '0); end
         PH_DR_SHIFT: begin seg_last = L_DRS;  tms_n = (cnt_q == L_DRS); end
         PH_DR_TAIL:  begin seg_last = L_TAIL; tms_n = (cnt_q == '0); end
         default:     begin seg_last = '0;     tms_n = 1'b1; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cmd_q    <= CMD_OPEN;
         cnt_q    <= '0;
         frames_q <= '0;
      end else if (launch_i) begin
         phase_q  <= PH_RST;
         cmd_q    <= CMD_OPEN;
         cnt_q    <= '0;
         frames_q <= '0;
      end else if (fall_i && phase_q == PH_FIN) begin
         phase_q  <= PH_IDLE;
      end else if (rise_i && phase_q != PH_IDLE && phase_q != PH_FIN) begin
         if (cnt_q != seg_last) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
            case (phase_q)
               PH_RST:      phase_q <= PH_RTI0;
               PH_RTI0:     begin phase_q <= PH_IR_HEAD; cmd_q <= CMD_OPEN; end
               PH_IR_HEAD:  phase_q <= PH_IR_SHIFT;
               PH_IR_SHIFT: phase_q <= PH_IR_TAIL;
               PH_IR_TAIL: begin
                  case (cmd_q)
                     CMD_OPEN: begin phase_q <= PH_IR_HEAD; cmd_q <= CMD_ADDR; end
                     CMD_ADDR: begin phase_q <= PH_IR_HEAD; cmd_q <= CMD_READ; end
                     CMD_READ: phase_q <= PH_DR_HEAD;
                     default:  phase_q <= PH_FIN;
                  endcase
               end
               PH_DR_HEAD:  phase_q <= PH_DR_SHIFT;
               PH_DR_SHIFT: phase_q <= PH_DR_TAIL;
               PH_DR_TAIL: begin
                  frames_q <= frames_q + 1'b1;
                  phase_q  <= PH_IR_HEAD;
                  cmd_q    <= (frames_q == L_FRM) ? CMD_CLOSE : CMD_READ;
               end
               default:     phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tms_q <= 1'b1;
         tdi_q <= 1'b0;
      end else if (launch_i) begin
         tms_q <= 1'b1;
         tdi_q <= 1'b0;
      end else if (fall_i) begin
         tms_q <= tms_n;
         tdi_q <= tdi_n;
      end
   end

   assign tms_o     = tms_q;
   assign tdi_o     = tdi_q;
   assign bit_vld_o = rise_i && (phase_q == PH_DR_SHIFT);
   assign bit_o     = tdo_i;
   assign finish_o  = fall_i && (phase_q == PH_FIN);
   assign frames_o  = frames_q;

   a_r9_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
      frames_o <= FCNT_W'(FRAME_COUNT));

   a_r7_tdi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld_o |-> !tdi_o);

endmodule

// File: rtl/jrb_readback_seq.sv
module jrb_readback_seq
   import jrb_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int IR_LEN      = 8,
   parameter int FRAME_BITS  = 3376,
   parameter int FRAME_COUNT = 1342,
   parameter int RESET_TCKS  = 5,
   parameter int CHK_W       = 16,
   parameter logic [IR_LEN-1:0] CODE_OPEN  = 8'h15,
   parameter logic [IR_LEN-1:0] CODE_ADDR  = 8'h12,
   parameter logic [IR_LEN-1:0] CODE_READ  = 8'h03,
   parameter logic [IR_LEN-1:0] CODE_CLOSE = 8'h3A,
   localparam int FCNT_W = $clog2(FRAME_COUNT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DIV_W-1:0]  half_per_i,
   input  logic              tdo_i,
   output logic              tck_o,
   output logic              tms_o,
   output logic              tdi_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [CHK_W-1:0]  checksum_o,
   output logic [FCNT_W-1:0] frames_o
);

   generate
      if (RESET_TCKS < 5) begin : g_chk_rst
         $error("RESET_TCKS must be at least 5");
      end
      if (IR_LEN < 2) begin : g_chk_ir
         $error("IR_LEN must be at least 2");
      end
      if (CHK_W < 3 || (FRAME_BITS % CHK_W) != 0) begin : g_chk_frame
         $error("FRAME_BITS must be a whole number of checksum words");
      end
      if (FRAME_COUNT < 1) begin : g_chk_cnt
         $error("FRAME_COUNT must be at least 1");
      end
   endgenerate

   logic             busy_q, done_q;
   logic [DIV_W-1:0] half_q;
   logic             launch;
   logic             rise, fall;
   logic             bit_vld, bit_val, finish;

   assign launch = start_i && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         half_q <= '0;
      end else begin
         done_q <= finish;
         if (launch) begin
            busy_q <= 1'b1;
            half_q <= half_per_i;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
      end
   end

   jrb_tck_gen #(.DIV_W(DIV_W)) u_tck (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy_q),
      .half_i (half_q),
      .tck_o  (tck_o),
      .rise_o (rise),
      .fall_o (fall)
   );

   jrb_tap_walker #(
      .IR_LEN      (IR_LEN),
      .FRAME_BITS  (FRAME_BITS),
      .FRAME_COUNT (FRAME_COUNT),
      .RESET_TCKS  (RESET_TCKS),
      .CODE_OPEN   (CODE_OPEN),
      .CODE_ADDR   (CODE_ADDR),
      .CODE_READ   (CODE_READ),
      .CODE_CLOSE  (CODE_CLOSE),
      .FCNT_W      (FCNT_W)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_i  (launch),
      .rise_i    (rise),
      .fall_i    (fall),
      .tdo_i     (tdo_i),
      .tms_o     (tms_o),
      .tdi_o     (tdi_o),
      .bit_vld_o (bit_vld),
      .bit_o     (bit_val),
      .finish_o  (finish),
      .frames_o  (frames_o)
   );

   jrb_checksum #(.CHK_W(CHK_W), .MSB_FIRST(1'b1)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (launch),
      .vld_i (bit_vld),
      .bit_i (bit_val),
      .sum_o (checksum_o)
   );

   assign busy_o = busy_q;
   assign done_o = done_q;

   a_r3_tms_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tms_o) |-> $fell(tck_o));

   a_r3_tdi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tdi_o) |-> $fell(tck_o));

   a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !tck_o);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r10_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> ($stable(checksum_o) && $stable(frames_o)));

endmodule

// File: tb/test_jrb_readback_seq.sv
module test_jrb_readback_seq;

   localparam int FB  = 64;
   localparam int FC  = 5;
   localparam int RT  = 5;
   localparam int DW  = 8;
   localparam int FW  = $clog2(FC + 1);
   localparam int WD  = 60000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DW-1:0] half_per = '0;
   logic tdo = 1'b0;
   logic tck, tms, tdi, busy, done;
   logic [15:0] checksum;
   logic [FW-1:0] frames;

   always #2 clk = ~clk;

   jrb_readback_seq #(.DIV_W(DW), .FRAME_BITS(FB), .FRAME_COUNT(FC), .RESET_TCKS(RT))
   i_jrb_readback_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .half_per_i(half_per),
      .tdo_i(tdo), .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .busy_o(busy),
      .done_o(done), .checksum_o(checksum), .frames_o(frames));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural TAP model ----------------
   typedef enum {TLR, RTI, SELDR, CAPDR, SHDR, EX1DR, PADR, EX2DR, UPDR,
                 SELIR, CAPIR, SHIR, EX1IR, PAIR, EX2IR, UPIR} tap_t;
   tap_t st = PADR;
   logic [7:0] ir_sh = '0, ir_cur = '0;
   logic [7:0] ir_log [0:31];
   int ir_n = 0, ir_bits = 0, ir_bad = 0;
   int dr_bits = 0, dr_bad = 0, dr_scans = 0, frame_m = 0;
   int rise_cnt = 0, first_zero = -1;
   logic [31:0] seed = 0;

   function automatic bit bitfn(input int f, input int i, input logic [31:0] s);
      logic [31:0] x;
      x = (f * 32'h9E3779B1) ^ (i * 32'h85EBCA6B) ^ s;
      x = x ^ (x >> 13);
      x = x * 32'hC2B2AE35;
      return x[16];
   endfunction

   function automatic logic [15:0] exp_sum(input logic [31:0] s);
      logic [15:0] acc = '0;
      for (int f = 0; f < FC; f++) begin
         for (int w = 0; w < FB / 16; w++) begin
            logic [15:0] word = '0;
            for (int k = 0; k < 16; k++) word = {word[14:0], bitfn(f, w * 16 + k, s)};
            acc = acc + word;
         end
      end
      return acc;
   endfunction

   always @(posedge tck) begin
      rise_cnt++;
      if (!tms && first_zero < 0) first_zero = rise_cnt - 1;
      case (st)
         CAPIR: ir_bits = 0;
         SHIR:  begin ir_sh = {tdi, ir_sh[7:1]}; ir_bits++; end
         UPIR:  begin
            ir_cur = ir_sh;
            if (ir_n < 32) ir_log[ir_n] = ir_sh;
            ir_n++;
            if (ir_bits != 8) ir_bad++;
         end
         CAPDR: dr_bits = 0;
         SHDR:  dr_bits++;
         UPDR:  if (ir_cur == 8'h03) begin
            dr_scans++;
            if (dr_bits != FB) dr_bad++;
            frame_m++;
         end
         default: ;
      endcase
      case (st)
         TLR:   st = tms ? TLR   : RTI;
         RTI:   st = tms ? SELDR : RTI;
         SELDR: st = tms ? SELIR : CAPDR;
         CAPDR: st = tms ? EX1DR : SHDR;
         SHDR:  st = tms ? EX1DR : SHDR;
         EX1DR: st = tms ? UPDR  : PADR;
         PADR:  st = tms ? EX2DR : PADR;
         EX2DR: st = tms ? UPDR  : SHDR;
         UPDR:  st = tms ? SELDR : RTI;
         SELIR: st = tms ? TLR   : CAPIR;
         CAPIR: st = tms ? EX1IR : SHIR;
         SHIR:  st = tms ? EX1IR : SHIR;
         EX1IR: st = tms ? UPIR  : PAIR;
         PAIR:  st = tms ? EX2IR : PAIR;
         EX2IR: st = tms ? UPIR  : SHIR;
         default: st = tms ? SELDR : RTI;
      endcase
   end

   always @(negedge tck)
      tdo = (st == SHDR && ir_cur == 8'h03) ? bitfn(frame_m, dr_bits, seed) : 1'b0;

   // ---------------- pin timing monitor ----------------
   int err_half = 0, err_edge = 0, seg_len = 0, cur_h = 0;
   logic p_tck = 1'b0, p_tms = 1'b1, p_tdi = 1'b0, p_busy = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ((tms !== p_tms || tdi !== p_tdi) && !(p_tck && !tck)) err_edge++;
         if (busy && !p_busy) seg_len = 1;
         else if (busy) begin
            if (tck !== p_tck) begin
               if (seg_len != cur_h + 1) err_half++;
               seg_len = 1;
            end else seg_len++;
         end
      end
      p_tck = tck; p_tms = tms; p_tdi = tdi; p_busy = busy;
   end

   // ---------------- one readback run ----------------
   task automatic run_one(input int h, input bit poke);
      int n;
      logic [15:0] hold_sum;
      logic [FW-1:0] hold_frm;
      logic [7:0] exp_ir;
      seed = $urandom;
      cur_h = h;
      st = PADR; ir_cur = '0; ir_n = 0; ir_bad = 0;
      dr_scans = 0; dr_bad = 0; frame_m = 0;
      rise_cnt = 0; first_zero = -1; err_half = 0; err_edge = 0;
      @(negedge clk);
      half_per = DW'(h);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10 busy after start", busy, 1);
      n = 0;
      if (poke) begin
         repeat (300) @(negedge clk);
         half_per = DW'(h + 2);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         n = 301;
      end
      while (done !== 1'b1 && n < WD) begin
         @(negedge clk);
         n++;
      end
      if (n >= WD) begin
         chk(1'b0, "watchdog", n, WD);
         return;
      end
      chk(busy === 1'b0, "R10 busy low with done", busy, 0);
      @(negedge clk);
      chk(done === 1'b0, "R10 done single cycle", done, 0);
      chk(checksum === exp_sum(seed), "R8 checksum", checksum, exp_sum(seed));
      chk(frames === FW'(FC), "R9 frame count", frames, FC);
      chk(ir_n == FC + 3, "R6 instruction count", ir_n, FC + 3);
      for (int i = 0; i < FC + 3 && i < 32; i++) begin
         exp_ir = (i == 0) ? 8'h15 : (i == 1) ? 8'h12 : (i == FC + 2) ? 8'h3A : 8'h03;
         chk(ir_log[i] === exp_ir, "R6 instruction order", ir_log[i], exp_ir);
      end
      chk(ir_bad == 0, "R5 eight-bit instruction scans", ir_bad, 0);
      chk(dr_scans == FC && dr_bad == 0, "R7 frame scans", dr_scans * 1000 + dr_bad, FC * 1000);
      chk(st == RTI, "R7 TAP ends in Run-Test/Idle", st, RTI);
      chk(first_zero == RT, "R4 TAP reset length", first_zero, RT);
      chk(err_half == 0, "R2 TCK phase length", err_half, 0);
      chk(err_edge == 0, "R3 TMS/TDI change on falling TCK", err_edge, 0);
      hold_sum = checksum;
      hold_frm = frames;
      repeat (20) @(negedge clk);
      chk(checksum === hold_sum && frames === hold_frm, "R9 results hold while idle",
          checksum, hold_sum);
      chk(tck === 1'b0 && tms === 1'b1, "R2 idle TCK low", {tck, tms}, 1);
   endtask

   int cyc = 0;
   always @(posedge clk) cyc++;

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
      chk(tck === 1'b0 && tms === 1'b1 && tdi === 1'b0, "R1 pins after reset",
          {tck, tms, tdi}, 3'b010);
      chk(checksum === 16'd0 && frames === '0, "R1 results after reset", checksum, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_one(0, 1'b0);
      run_one(3, 1'b0);
      run_one(int'($urandom_range(0, 5)), 1'b1);
      for (int r = 0; r < 2; r++) run_one(int'($urandom_range(0, 5)), 1'b0);
      if (cyc > 190000) chk(1'b0, "watchdog total", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 195000);
      chk(1'b0, "watchdog global", cyc, 195000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule